// File: doc/BRIEF.md
# Power-Analysis Test Vector Stager

This block sits between a measurement controller and an authenticated cipher under test. The controller sends a complete test vector as one byte stream. The stream is cut into segments. Each segment opens with a three-byte header: a destination code, then a 16-bit payload length with the high byte first. The payload bytes are then routed into one of three loading FIFOs: public data, secret data or masking randomness. A fourth FIFO collects whatever the cipher produces.

A header byte of 0xFF asks for a run. If no error has been recorded, the block raises a one-cycle pulse that serves both as the oscilloscope trigger and as the cipher's start. The external input is then closed. The cipher drains the loading FIFOs and fills the result FIFO. When the cipher signals completion, the collected bytes are streamed back over a valid/ready output. Only after that does the block accept a new header.

The control FSM has seven states:
- `ST_ID`: waiting for the destination byte.
- `ST_LEN_HI` and `ST_LEN_LO`: receiving the two length bytes.
- `ST_BODY`: routing payload bytes.
- `ST_FIRE`: the trigger cycle.
- `ST_RUN`: the cipher is working.
- `ST_RETURN`: the result FIFO is being emptied.

The transitions are:
- `ST_ID` goes to `ST_LEN_HI` on any accepted byte other than 0xFF.
- `ST_ID` goes to `ST_FIRE` on 0xFF when no error is recorded. With an error recorded, 0xFF keeps it in `ST_ID`.
- `ST_LEN_HI` goes to `ST_LEN_LO`.
- `ST_LEN_LO` goes to `ST_BODY` for a nonzero length, or back to `ST_ID` for length zero.
- `ST_BODY` goes to `ST_ID` after the last payload byte.
- `ST_FIRE` goes to `ST_RUN` unconditionally.
- `ST_RUN` goes to `ST_RETURN` on `cipher_done`.
- `ST_RETURN` goes to `ST_ID` once the result FIFO is empty.

Top module: `sca_vector_stager`

## Requirements
- R1: A segment is a destination byte (0 = public, 1 = secret, 2 = random), then a length high byte, then a length low byte, then that many payload bytes. The payload bytes reach the chosen FIFO in arrival order. Several segments to the same FIFO append to it.
- R2: A segment of length zero uses only its three header bytes. The next byte is taken as a new destination byte.
- R3: While a vector is loading, `pub_valid`, `sec_valid`, `rnd_valid` and `out_valid` stay low, even when the FIFOs hold data.
- R4: An accepted 0xFF destination byte with no recorded error makes `scope_trig` and `cipher_go` high for exactly the one cycle after that byte's clock edge.
- R5: From the trigger cycle until the result FIFO has been emptied, `in_ready` is low. During the trigger cycle and `ST_RUN`, `out_valid` is low.
- R6: In `ST_RUN`, each loading FIFO offers its head byte on its cipher-side valid/ready port. The result FIFO accepts `res_data` whenever `res_ready` is high.
- R7: After a one-cycle `cipher_done`, the result bytes leave on `out_data` in the order they were written. A byte leaves only on a cycle with `out_valid` and `out_ready` both high. Once the result FIFO is empty, `in_ready` rises again.
- R8: A payload byte aimed at a full FIFO is dropped and sets `err_flag`. `err_flag` stays high until reset.
- R9: A destination byte other than 0, 1, 2 or 0xFF sets `err_flag`.
- R10: A 0xFF byte arriving while `err_flag` is high is consumed without effect. No trigger follows, and `in_ready` stays high.
- R11: After reset, `in_ready` is high, and `scope_trig`, `cipher_go`, `err_flag` and all valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Vector stream byte from the controller |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Stream byte accepted this cycle |
| out_data | output | 8 | Returned result byte |
| out_valid | output | 1 | Result byte present |
| out_ready | input | 1 | Controller takes the result byte |
| scope_trig | output | 1 | One-cycle oscilloscope trigger |
| err_flag | output | 1 | Sticky load error |
| cipher_go | output | 1 | One-cycle cipher start |
| cipher_done | input | 1 | Cipher finished |
| pub_data | output | 8 | Public data head byte |
| pub_valid | output | 1 | Public byte offered |
| pub_ready | input | 1 | Cipher takes public byte |
| sec_data | output | 8 | Secret data head byte |
| sec_valid | output | 1 | Secret byte offered |
| sec_ready | input | 1 | Cipher takes secret byte |
| rnd_data | output | 8 | Randomness head byte |
| rnd_valid | output | 1 | Random byte offered |
| rnd_ready | input | 1 | Cipher takes random byte |
| res_data | input | 8 | Cipher output byte |
| res_valid | input | 1 | Cipher output byte present |
| res_ready | output | 1 | Result FIFO accepts byte |

## Verification
The hardest situation to reach from the ports is a refused run, because it needs an error to be latched before the 0xFF byte arrives. The bench gets there in two ways. It sends a public segment one byte longer than the FIFO depth, and separately it sends an unused destination code; each time it then checks that 0xFF produces no trigger. Normal runs sweep the public, secret and random segment lengths, including zero-length segments and a public segment split in two. A stub cipher echoes the data back, and the bench throttles `out_ready` on alternate runs.

// File: rtl/sca_stage_pkg.sv
package sca_stage_pkg;
    typedef enum logic [2:0] {
        ST_ID,
        ST_LEN_HI,
        ST_LEN_LO,
        ST_BODY,
        ST_FIRE,
        ST_RUN,
        ST_RETURN
    } stage_state_e;

    localparam int          BYTE_W   = 8;
    localparam int          LEN_W    = 16;
    localparam int          N_LOAD   = 3;
    localparam int          N_FIFO   = N_LOAD + 1;
    localparam logic [7:0]  DEST_GO  = 8'hFF;
endpackage

// File: rtl/sca_byte_fifo.sv
module sca_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= wp + 1'b1;
            if (rd_en) rp <= rp + 1'b1;
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign full    = (cnt == CNT_FULL);
    assign empty   = (cnt == '0);
    assign rd_data = mem[rp];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);
endmodule

// File: rtl/sca_stage_ctrl.sv
module sca_stage_ctrl
    import sca_stage_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [N_LOAD-1:0]  load_full,
    output logic [N_LOAD-1:0]  load_wr,
    input  logic               res_empty,
    input  logic               cipher_done,
    output logic               fire,
    output logic               running,
    output logic               returning,
    output logic               err
);
    stage_state_e      state, nxt;
    logic [7:0]        dest;
    logic [7:0]        len_hi;
    logic [LEN_W-1:0]  remain;
    logic              accept;
    logic              id_known;
    logic              dest_ok;
    logic              dest_full;

    assign accept   = in_valid && in_ready;
    assign id_known = (in_data < 8'(N_LOAD)) || (in_data == DEST_GO);
    assign dest_ok  = dest < 8'(N_LOAD);

    always_comb begin
        dest_full = 1'b0;
        for (int k = 0; k < N_LOAD; k++) begin
            if (dest == 8'(k)) dest_full = load_full[k];
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ID:     if (accept) nxt = (in_data == DEST_GO) ? (err ? ST_ID : ST_FIRE) : ST_LEN_HI;
            ST_LEN_HI: if (accept) nxt = ST_LEN_LO;
            ST_LEN_LO: if (accept) nxt = ({len_hi, in_data} == '0) ? ST_ID : ST_BODY;
            ST_BODY:   if (accept && remain == LEN_W'(1)) nxt = ST_ID;
            ST_FIRE:   nxt = ST_RUN;
            ST_RUN:    if (cipher_done) nxt = ST_RETURN;
            ST_RETURN: if (res_empty) nxt = ST_ID;
            default:   nxt = ST_ID;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ID;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest   <= '0;
            len_hi <= '0;
            remain <= '0;
            err    <= 1'b0;
        end else begin
            if (accept && state == ST_ID)     dest   <= in_data;
            if (accept && state == ST_LEN_HI) len_hi <= in_data;
            if (accept && state == ST_LEN_LO) remain <= {len_hi, in_data};
            if (accept && state == ST_BODY)   remain <= remain - 1'b1;
            if (accept && state == ST_ID && !id_known) err <= 1'b1;
            if (accept && state == ST_BODY && (!dest_ok || dest_full)) err <= 1'b1;
        end
    end

    always_comb begin
        in_ready  = (state == ST_ID) || (state == ST_LEN_HI) ||
                    (state == ST_LEN_LO) || (state == ST_BODY);
        fire      = (state == ST_FIRE);
        running   = (state == ST_RUN);
        returning = (state == ST_RETURN);
        load_wr   = '0;
        for (int k = 0; k < N_LOAD; k++) begin
            if (state == ST_BODY && accept && dest == 8'(k) && !load_full[k])
                load_wr[k] = 1'b1;
        end
    end

    // R4
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |=> !fire);
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
    // R10
    fire_clean_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |-> !err);
endmodule

// File: rtl/sca_vector_stager.sv
module sca_vector_stager
    import sca_stage_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       scope_trig,
    output logic       err_flag,
    output logic       cipher_go,
    input  logic       cipher_done,
    output logic [7:0] pub_data,
    output logic       pub_valid,
    input  logic       pub_ready,
    output logic [7:0] sec_data,
    output logic       sec_valid,
    input  logic       sec_ready,
    output logic [7:0] rnd_data,
    output logic       rnd_valid,
    input  logic       rnd_ready,
    input  logic [7:0] res_data,
    input  logic       res_valid,
    output logic       res_ready
);
    localparam int RES = N_LOAD;

    logic [N_FIFO-1:0] f_wr, f_rd, f_full, f_empty;
    logic [7:0]        f_wd [N_FIFO];
    logic [7:0]        f_rdd [N_FIFO];
    logic [N_LOAD-1:0] load_wr;
    logic              fire, running, returning;

    sca_stage_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .load_full   (f_full[N_LOAD-1:0]),
        .load_wr     (load_wr),
        .res_empty   (f_empty[RES]),
        .cipher_done (cipher_done),
        .fire        (fire),
        .running     (running),
        .returning   (returning),
        .err         (err_flag)
    );

    generate
        for (genvar g = 0; g < N_FIFO; g++) begin : g_fifo
            sca_byte_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (f_wr[g]),
                .wr_data (f_wd[g]),
                .full    (f_full[g]),
                .rd_en   (f_rd[g]),
                .rd_data (f_rdd[g]),
                .empty   (f_empty[g])
            );
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < N_LOAD; k++) begin
            f_wr[k] = load_wr[k];
            f_wd[k] = in_data;
        end
        res_ready   = running && !f_full[RES];
        f_wr[RES]   = res_valid && res_ready;
        f_wd[RES]   = res_data;

        pub_valid   = running && !f_empty[0];
        sec_valid   = running && !f_empty[1];
        rnd_valid   = running && !f_empty[2];
        pub_data    = f_rdd[0];
        sec_data    = f_rdd[1];
        rnd_data    = f_rdd[2];
        f_rd[0]     = pub_valid && pub_ready;
        f_rd[1]     = sec_valid && sec_ready;
        f_rd[2]     = rnd_valid && rnd_ready;

        out_valid   = returning && !f_empty[RES];
        out_data    = f_rdd[RES];
        f_rd[RES]   = out_valid && out_ready;

        scope_trig  = fire;
        cipher_go   = fire;
    end

    // R3
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pub_valid || sec_valid || rnd_valid || out_valid) |-> !in_ready);
    // R5
    run_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scope_trig || res_ready) |-> (!in_ready && !out_valid));
endmodule

// File: tb/tb_sca_vector_stager.sv
module tb_sca_vector_stager;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       scope_trig, err_flag, cipher_go;
    logic       cipher_done = 1'b0;
    logic [7:0] pub_data, sec_data, rnd_data;
    logic       pub_valid, sec_valid, rnd_valid;
    logic       pub_ready = 1'b0, sec_ready = 1'b0, rnd_ready = 1'b0;
    logic [7:0] res_data = '0;
    logic       res_valid = 1'b0;
    logic       res_ready;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sca_vector_stager #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .scope_trig(scope_trig), .err_flag(err_flag), .cipher_go(cipher_go), .cipher_done(cipher_done),
        .pub_data(pub_data), .pub_valid(pub_valid), .pub_ready(pub_ready),
        .sec_data(sec_data), .sec_valid(sec_valid), .sec_ready(sec_ready),
        .rnd_data(rnd_data), .rnd_valid(rnd_valid), .rnd_ready(rnd_ready),
        .res_data(res_data), .res_valid(res_valid), .res_ready(res_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b);
        chk(in_ready, "R1 in_ready during load", in_ready, 1);
        in_data  = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic seg(input logic [7:0] id, input int len, input int base);
        send(id);
        send(8'(len >> 8));
        send(8'(len));
        for (int i = 0; i < len; i++) send(8'(base + i));
    endtask

    task automatic run_vector(input int np, input int ns, input int nr, input bit throttle);
        logic [7:0] got [32];
        int k, pbase, sbase, rbase, half;
        pbase = 8'h10 * np;
        sbase = 8'h80 + np;
        rbase = 8'hC0 + 3 * np;
        half  = np / 2;
        // R1 / R2: public split in two with an empty segment between
        seg(8'd0, half, pbase);
        seg(8'd0, 0, 0);
        seg(8'd1, ns, sbase);
        seg(8'd2, nr, rbase);
        seg(8'd0, np - half, pbase + half);
        // R3
        chk(!pub_valid && !sec_valid && !out_valid, "R3 cipher side idle while loading", pub_valid, 0);
        send(8'hFF);
        // R4
        chk(scope_trig && cipher_go, "R4 trigger after start byte", scope_trig, 1);
        chk(!in_ready, "R5 input closed on trigger", in_ready, 0);
        in_data  = 8'h00;
        in_valid = 1'b1;
        @(negedge clk);
        chk(!scope_trig, "R4 trigger lasts one cycle", scope_trig, 0);
        // R6 public
        k = 0;
        while (pub_valid && k < 32) begin
            got[k] = pub_data; pub_ready = 1'b1; @(negedge clk); pub_ready = 1'b0; k++;
        end
        chk(k == np, "R6 public count", k, np);
        for (int i = 0; i < np; i++) chk(got[i] == 8'(pbase + i), "R1 public byte", got[i], 8'(pbase + i));
        k = 0;
        while (sec_valid && k < 32) begin
            got[16 + k] = sec_data; sec_ready = 1'b1; @(negedge clk); sec_ready = 1'b0; k++;
        end
        chk(k == ns, "R6 secret count", k, ns);
        for (int i = 0; i < ns; i++) chk(got[16 + i] == 8'(sbase + i), "R1 secret byte", got[16 + i], 8'(sbase + i));
        k = 0;
        while (rnd_valid && k < 32) begin
            chk(rnd_data == 8'(rbase + k), "R1 random byte", rnd_data, 8'(rbase + k));
            rnd_ready = 1'b1; @(negedge clk); rnd_ready = 1'b0; k++;
        end
        chk(k == nr, "R2 random count incl zero length", k, nr);
        // R5 during run
        chk(!in_ready && !out_valid, "R5 no external I/O in run", in_ready, 0);
        for (int i = 0; i < np; i++) begin
            chk(res_ready, "R6 result fifo accepts", res_ready, 1);
            res_data = 8'(pbase + i) ^ 8'(sbase); res_valid = 1'b1;
            @(negedge clk);
            res_valid = 1'b0;
        end
        cipher_done = 1'b1;
        @(negedge clk);
        cipher_done = 1'b0;
        in_valid = 1'b0;
        // R7 return
        k = 0;
        for (int c = 0; c < 64 && out_valid; c++) begin
            out_ready = throttle ? 1'(c % 2) : 1'b1;
            if (out_valid && out_ready) begin
                chk(out_data == (8'(pbase + k) ^ 8'(sbase)), "R7 returned byte", out_data, 8'(pbase + k) ^ 8'(sbase));
                k++;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(k == np, "R7 returned count", k, np);
        @(negedge clk);
        chk(in_ready, "R7 input reopens after return", in_ready, 1);
        chk(!err_flag, "R8 no error on clean vector", err_flag, 0);
    endtask

    initial begin
        do_reset();
        // R11
        chk(in_ready && !scope_trig && !cipher_go && !err_flag && !out_valid &&
            !pub_valid && !sec_valid && !rnd_valid && !res_ready, "R11 reset state", in_ready, 1);
        for (int n = 1; n <= DEPTH; n++) run_vector(n, (n % 3) + 1, n % 4, bit'(n % 2));

        // R8 overflow of public FIFO, then R10 refused start
        do_reset();
        seg(8'd0, DEPTH + 1, 8'h40);
        chk(err_flag, "R8 overflow sets error", err_flag, 1);
        send(8'hFF);
        chk(!scope_trig && in_ready, "R10 start refused after overflow", scope_trig, 0);
        @(negedge clk);
        chk(!scope_trig && !pub_valid && err_flag, "R10 still idle, error sticky", scope_trig, 0);

        // R9 unknown destination code
        do_reset();
        chk(!err_flag, "R11 reset clears error", err_flag, 0);
        send(8'h07);
        chk(err_flag, "R9 unknown destination sets error", err_flag, 1);
        send(8'h00);
        send(8'h00);
        send(8'hFF);
        chk(!scope_trig && in_ready, "R10 start refused after bad code", scope_trig, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule